// File: doc/BRIEF.md
# Key Matrix Scanner with Hold-to-Repeat

This block scans a keypad wired as a grid of column drive lines and row sense lines. It raises one column select at a time and leaves it on for a fixed number of clocks, so the row lines can settle. On the last clock of that dwell it samples all rows in parallel. After every column has been sampled once, the block has a full frame of row bytes, one per column. A frame with two or more closed switches anywhere in the grid counts as contact bounce or ghosting and is thrown away. Only frames with zero or one closed switch are accepted. Any switch that is closed in an accepted frame but was open in the previous accepted frame is reported as a first-press event.

While one switch stays closed, the block counts pulses on an external timer tick input. When the long initial delay runs out, it reports a repeat event for the same switch. After that it repeats at a shorter fixed period. Releasing the switch stops the repeats. Moving to a different switch starts the long delay again. Every event is a one-cycle strobe carrying a key code, plus a flag that tells a first press from a repeat.

Top module: `kmx_scanner`

## Requirements
- R1: `col_sel` is one-hot at all times and steps through columns 0, 1, ..., NUM_COLS-1 and back to 0. Each column stays selected for exactly SETTLE_CLKS (default 4) clock cycles. The rows are sampled on the final cycle of each column's dwell.
- R2: A row input at 1 means a closed switch. One frame is the set of row samples for all columns, one byte per column, taken in a single pass.
- R3: When an accepted frame holds a switch that was open in the previous accepted frame, `key_evt` pulses for one cycle with `key_rpt`=0. The pulse comes in the cycle after the last column is sampled. `key_code` = column*8 + row: the column index sits in bits [5:3] and the row index in bits [2:0].
- R4: A switch that stays closed over several frames gives no further first-press events.
- R5: A frame with two or more closed switches, whether in the same column or in different columns, produces no event and leaves the accepted state unchanged. The next single-switch frame is compared against the last accepted frame.
- R6: While a switch stays closed, the 128th tick after its first press gives a `key_evt` with `key_rpt`=1 and the same code. Further repeats follow every 20 ticks.
- R7: An accepted frame with no closed switch stops repeating and reloads the countdown to 128. The next press of any switch waits a full 128 ticks before its first repeat.
- R8: Going from one switch directly to another in a single frame gives a first-press event for the new switch and reloads the countdown to 128.
- R9: When a frame evaluation and a tick that would end the countdown fall in the same cycle, the frame result wins. A release or a new switch suppresses that repeat. An accepted frame that still shows the same switch lets the repeat through.
- R10: While reset is active and right after it is released, `key_evt`=0, `key_rpt`=0, `key_code`=0 and `col_sel` selects column 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timebase pulse for the repeat countdown |
| rows | input | 8 | Row sense lines, 1 = switch closed |
| col_sel | output | 6 | One-hot column drive |
| key_evt | output | 1 | One-cycle event strobe |
| key_rpt | output | 1 | 1 = repeat event, 0 = first press |
| key_code | output | 6 | Column*8 + row of the reported switch |

## Verification
Two things can land on the same clock edge: the evaluation of a finished frame, and a tick that brings the repeat countdown to zero. To force this, the bench waits until the last column is selected and raises the tick exactly on that column's sampling edge, after giving 127 ticks to a held switch. It runs the collision three times: with the switch released, with it moved to another switch, and with it still held. The scoreboard then checks that only the frame's verdict is seen in the first two cases, and that the repeat arrives on its expected tick count in the third.

// File: rtl/kmx_pkg.sv
package kmx_pkg;

    // Width needed to index n items (at least one bit).
    function automatic int unsigned bits_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef enum logic [1:0] {
        EVK_NONE   = 2'd0,
        EVK_PRESS  = 2'd1,
        EVK_REPEAT = 2'd2
    } evt_kind_e;

endpackage

// File: rtl/kmx_col_stepper.sv
module kmx_col_stepper
    import kmx_pkg::*;
#(
    parameter int unsigned NUM_COLS    = 6,
    parameter int unsigned SETTLE_CLKS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic [NUM_COLS-1:0]           col_sel,
    output logic [bits_for(NUM_COLS)-1:0] col_idx,
    output logic                          sample_stb,
    output logic                          frame_end
);
    localparam int unsigned COL_W = bits_for(NUM_COLS);
    localparam int unsigned SET_W = bits_for(SETTLE_CLKS);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(NUM_COLS - 1);
    localparam logic [SET_W-1:0] LAST_WAIT = SET_W'(SETTLE_CLKS - 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [SET_W-1:0] wait_cnt;
    } step_t;

    step_t st_d, st_q;
    logic  stb;

    always_comb begin
        st_d = st_q;
        stb  = (st_q.wait_cnt == LAST_WAIT);
        if (stb) begin
            st_d.wait_cnt = '0;
            st_d.col      = (st_q.col == LAST_COL) ? '0 : st_q.col + COL_W'(1);
        end else begin
            st_d.wait_cnt = st_q.wait_cnt + SET_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_COLS; g++) begin : g_drive
        assign col_sel[g] = (st_q.col == COL_W'(g));
    end

    assign col_idx    = st_q.col;
    assign sample_stb = stb;
    assign frame_end  = stb && (st_q.col == LAST_COL);

endmodule

// File: rtl/kmx_frame_judge.sv
module kmx_frame_judge
    import kmx_pkg::*;
#(
    parameter int unsigned NUM_COLS = 6,
    parameter int unsigned NUM_ROWS = 8
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic                                              sample_stb,
    input  logic                                              frame_end,
    input  logic [bits_for(NUM_COLS)-1:0]                     col_idx,
    input  logic [NUM_ROWS-1:0]                               rows,
    output logic                                              frame_ok,
    output logic                                              new_press,
    output logic                                              frame_empty,
    output logic [bits_for(NUM_COLS)+bits_for(NUM_ROWS)-1:0]  press_code
);
    localparam int unsigned COL_W = bits_for(NUM_COLS);
    localparam int unsigned ROW_W = bits_for(NUM_ROWS);
    localparam int unsigned KC_W  = bits_for(NUM_COLS * NUM_ROWS + 1);

    typedef logic [NUM_COLS-1:0][NUM_ROWS-1:0] map_t;

    typedef struct packed {
        logic [NUM_COLS-2:0][NUM_ROWS-1:0] scan;    // partial frame, all but last column
        map_t                              stable;  // last accepted frame
    } judge_t;

    judge_t                   st_d, st_q;
    map_t                     frame, fresh;
    logic [KC_W-1:0]          nkeys;
    logic [COL_W+ROW_W-1:0]   code;
    logic                     ok;

    always_comb begin
        frame = '0;
        for (int c = 0; c < NUM_COLS - 1; c++) begin
            frame[c] = st_q.scan[c];
        end
        frame[NUM_COLS-1] = rows;
        fresh = frame & ~st_q.stable;

        nkeys = '0;
        code  = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                nkeys = nkeys + KC_W'(frame[c][r]);
                if (fresh[c][r]) code = {COL_W'(c), ROW_W'(r)};
            end
        end
        ok = frame_end && (nkeys <= KC_W'(1));

        st_d = st_q;
        for (int c = 0; c < NUM_COLS - 1; c++) begin
            if (sample_stb && (col_idx == COL_W'(c))) st_d.scan[c] = rows;
        end
        if (ok) st_d.stable = frame;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign frame_ok    = ok;
    assign new_press   = ok && (|fresh);
    assign frame_empty = ok && (nkeys == '0);
    assign press_code  = code;

endmodule

// File: rtl/kmx_repeat_gen.sv
module kmx_repeat_gen
    import kmx_pkg::*;
#(
    parameter int unsigned CODE_W        = 6,
    parameter int unsigned FIRST_DELAY   = 128,
    parameter int unsigned REPEAT_PERIOD = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              frame_ok,
    input  logic              new_press,
    input  logic              frame_empty,
    input  logic [CODE_W-1:0] press_code,
    output logic              key_evt,
    output logic              key_rpt,
    output logic [CODE_W-1:0] key_code
);
    localparam int unsigned MAX_LD = (FIRST_DELAY > REPEAT_PERIOD) ? FIRST_DELAY : REPEAT_PERIOD;
    localparam int unsigned CNT_W  = bits_for(MAX_LD + 1);

    typedef struct packed {
        evt_kind_e         kind;
        logic [CODE_W-1:0] code;
        logic              held;
        logic [CODE_W-1:0] held_code;
        logic [CNT_W-1:0]  cnt;
    } rep_t;

    rep_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kind = EVK_NONE;
        if (new_press) begin
            st_d.kind      = EVK_PRESS;
            st_d.code      = press_code;
            st_d.held      = 1'b1;
            st_d.held_code = press_code;
            st_d.cnt       = CNT_W'(FIRST_DELAY);
        end else if (frame_empty) begin
            st_d.held = 1'b0;
            st_d.cnt  = CNT_W'(FIRST_DELAY);
        end else if (tick && st_q.held) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.kind = EVK_REPEAT;
                st_d.code = st_q.held_code;
                st_d.cnt  = CNT_W'(REPEAT_PERIOD);
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        // frame_ok alone (same switch reconfirmed) leaves the countdown running
        if (frame_ok && !new_press && !frame_empty) st_d.held = st_q.held;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{kind: EVK_NONE, code: '0, held: 1'b0, held_code: '0, cnt: CNT_W'(FIRST_DELAY)};
        else     st_q <= st_d;
    end

    assign key_evt  = (st_q.kind != EVK_NONE);
    assign key_rpt  = (st_q.kind == EVK_REPEAT);
    assign key_code = st_q.code;

endmodule

// File: rtl/kmx_scanner.sv
module kmx_scanner
    import kmx_pkg::*;
#(
    parameter int unsigned NUM_COLS      = 6,
    parameter int unsigned NUM_ROWS      = 8,
    parameter int unsigned SETTLE_CLKS   = 4,
    parameter int unsigned FIRST_DELAY   = 128,
    parameter int unsigned REPEAT_PERIOD = 20
) (
    input  logic                                             clk,
    input  logic                                             rst,
    input  logic                                             tick,
    input  logic [NUM_ROWS-1:0]                              rows,
    output logic [NUM_COLS-1:0]                              col_sel,
    output logic                                             key_evt,
    output logic                                             key_rpt,
    output logic [bits_for(NUM_COLS)+bits_for(NUM_ROWS)-1:0] key_code
);
    localparam int unsigned COL_W  = bits_for(NUM_COLS);
    localparam int unsigned CODE_W = COL_W + bits_for(NUM_ROWS);

    logic [COL_W-1:0]  col_idx;
    logic              sample_stb, frame_end;
    logic              frame_ok, new_press, frame_empty;
    logic [CODE_W-1:0] press_code;

    kmx_col_stepper #(
        .NUM_COLS   (NUM_COLS),
        .SETTLE_CLKS(SETTLE_CLKS)
    ) u_step (
        .clk       (clk),
        .rst       (rst),
        .col_sel   (col_sel),
        .col_idx   (col_idx),
        .sample_stb(sample_stb),
        .frame_end (frame_end)
    );

    kmx_frame_judge #(
        .NUM_COLS(NUM_COLS),
        .NUM_ROWS(NUM_ROWS)
    ) u_judge (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (sample_stb),
        .frame_end  (frame_end),
        .col_idx    (col_idx),
        .rows       (rows),
        .frame_ok   (frame_ok),
        .new_press  (new_press),
        .frame_empty(frame_empty),
        .press_code (press_code)
    );

    kmx_repeat_gen #(
        .CODE_W       (CODE_W),
        .FIRST_DELAY  (FIRST_DELAY),
        .REPEAT_PERIOD(REPEAT_PERIOD)
    ) u_rep (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .frame_ok   (frame_ok),
        .new_press  (new_press),
        .frame_empty(frame_empty),
        .press_code (press_code),
        .key_evt    (key_evt),
        .key_rpt    (key_rpt),
        .key_code   (key_code)
    );

endmodule

// File: rtl/kmx_scanner_chk.sv
module kmx_scanner_chk
    import kmx_pkg::*;
#(
    parameter int unsigned NUM_COLS    = 6,
    parameter int unsigned NUM_ROWS    = 8,
    parameter int unsigned SETTLE_CLKS = 4
) (
    input logic                                             clk,
    input logic                                             rst,
    input logic                                             tick,
    input logic [NUM_COLS-1:0]                              col_sel,
    input logic                                             key_evt,
    input logic                                             key_rpt,
    input logic [bits_for(NUM_COLS)+bits_for(NUM_ROWS)-1:0] key_code
);
    localparam int unsigned ROW_W = bits_for(NUM_ROWS);
    localparam int unsigned CW    = bits_for(NUM_COLS) + ROW_W;
    localparam int unsigned DW    = bits_for(SETTLE_CLKS + 2);

    logic [NUM_COLS-1:0] prev_sel_q;
    logic [DW-1:0]       dwell_q;
    logic [NUM_COLS-1:0] next_sel;

    assign next_sel = {prev_sel_q[NUM_COLS-2:0], prev_sel_q[NUM_COLS-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sel_q <= NUM_COLS'(1);
            dwell_q    <= '0;
        end else begin
            prev_sel_q <= col_sel;
            dwell_q    <= (col_sel != prev_sel_q) ? DW'(1) : dwell_q + DW'(1);
        end
    end

    AST_COL_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(col_sel) == 1); // R1

    AST_COL_DWELL: assert property (@(posedge clk) disable iff (rst)
        (col_sel != prev_sel_q) |-> (dwell_q == DW'(SETTLE_CLKS))); // R1

    AST_COL_ORDER: assert property (@(posedge clk) disable iff (rst)
        (col_sel != prev_sel_q) |-> (col_sel == next_sel)); // R1

    AST_PRESS_AFTER_LAST_COL: assert property (@(posedge clk) disable iff (rst)
        (key_evt && !key_rpt) |-> $past(col_sel[NUM_COLS-1])); // R3

    AST_CODE_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        key_evt |-> (key_code[CW-1:ROW_W] < NUM_COLS)); // R3

    AST_REPEAT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (key_evt && key_rpt) |-> $past(tick)); // R6

endmodule

bind kmx_scanner kmx_scanner_chk #(
    .NUM_COLS   (NUM_COLS),
    .NUM_ROWS   (NUM_ROWS),
    .SETTLE_CLKS(SETTLE_CLKS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .col_sel (col_sel),
    .key_evt (key_evt),
    .key_rpt (key_rpt),
    .key_code(key_code)
);

// File: tb/kmx_scanner_test.sv
module kmx_scanner_test;
    localparam int NC = 6;
    localparam int NR = 8;
    localparam int ST = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                   rst, tick;
    logic [NR-1:0]          rows;
    logic [NC-1:0]          col_sel;
    logic                   key_evt, key_rpt;
    logic [5:0]             key_code;
    logic [NC-1:0][NR-1:0]  keys;

    kmx_scanner uut (
        .clk(clk), .rst(rst), .tick(tick), .rows(rows),
        .col_sel(col_sel), .key_evt(key_evt), .key_rpt(key_rpt), .key_code(key_code)
    );

    // Keypad model: the selected column returns its closed switches.
    always_comb begin
        rows = '0;
        for (int c = 0; c < NC; c++) if (col_sel[c]) rows = rows | keys[c];
    end

    typedef struct {
        logic [5:0] code;
        logic       rpt;
        int         stamp;
        string      req;
    } exp_t;

    exp_t  exp_q[$];
    int    errors = 0, checks = 0, tick_count = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    function automatic logic [5:0] kc(input int c, input int r);
        return 6'(c * 8 + r);
    endfunction

    task automatic expect_evt(input int c, input int r, input logic rpt, input int stamp, input string req);
        exp_t e;
        e.code = kc(c, r); e.rpt = rpt; e.stamp = stamp; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && key_evt) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected event code", int'(key_code), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(key_code == e.code, e.req, "event code", int'(key_code), int'(e.code));
                check(key_rpt == e.rpt, e.req, "repeat flag", int'(key_rpt), int'(e.rpt));
                if (e.stamp >= 0)
                    check(tick_count == e.stamp, e.req, "tick count at event", tick_count, e.stamp);
            end
        end
    end

    task automatic sync_frame();
        do @(negedge clk); while (!col_sel[NC-1]);
        do @(negedge clk); while (!col_sel[0]);
    endtask

    // Change the keypad at a frame start; optionally tick on the frame-end edge.
    task automatic apply_keys(input logic [NC-1:0][NR-1:0] nk, input bit with_tick);
        sync_frame();
        keys = nk;
        if (with_tick) begin
            do @(negedge clk); while (!col_sel[NC-1]);
            repeat (ST - 1) @(negedge clk);
            tick = 1'b1;
            tick_count++;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    function automatic logic [NC-1:0][NR-1:0] one_key(input int c, input int r);
        logic [NC-1:0][NR-1:0] m;
        m = '0;
        m[c][r] = 1'b1;
        return m;
    endfunction

    task automatic give_ticks(input int n);
        repeat (n) begin
            @(negedge clk); tick = 1'b1; tick_count++;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        sync_frame();
        sync_frame();
        check(exp_q.size() == 0, req, "pending expected events", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic release_all();
        apply_keys('0, 1'b0);
        sync_frame();
        sync_frame();
    endtask

    task automatic press_and_wait(input int c, input int r, input string req);
        expect_evt(c, r, 1'b0, -1, req);
        apply_keys(one_key(c, r), 1'b0);
        drain(req);
        tick_count = 0;
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; keys = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(col_sel == 6'b000001, "R10", "col_sel after reset", int'(col_sel), 1);
        check(key_evt == 1'b0, "R10", "key_evt after reset", int'(key_evt), 0);
        check(key_rpt == 1'b0, "R10", "key_rpt after reset", int'(key_rpt), 0);
        check(key_code == 6'd0, "R10", "key_code after reset", int'(key_code), 0);

        // R1: column order and dwell over two frames
        cur_req = "R1";
        sync_frame();
        for (int k = 0; k < 2 * NC; k++) begin
            bit ok = 1'b1;
            for (int d = 0; d < ST; d++) begin
                if (col_sel != 6'(1 << (k % NC))) ok = 1'b0;
                @(negedge clk);
            end
            check(ok, "R1", "column dwell/order", int'(col_sel), 1 << ((k + 1) % NC));
        end

        // R3 / R2: first presses at several positions
        cur_req = "R3";
        press_and_wait(0, 0, "R3"); release_all();
        press_and_wait(5, 7, "R3"); release_all();
        press_and_wait(2, 3, "R2"); 
        // R4: held without ticks gives nothing more
        cur_req = "R4";
        sync_frame(); sync_frame(); sync_frame();
        drain("R4");
        release_all();

        // R5: two switches in different columns, then in the same column
        cur_req = "R5";
        begin
            logic [NC-1:0][NR-1:0] m;
            m = one_key(1, 2) | one_key(4, 6);
            apply_keys(m, 1'b0);
            drain("R5");
            expect_evt(4, 6, 1'b0, -1, "R5");
            apply_keys(one_key(4, 6), 1'b0);
            drain("R5");
            release_all();
            m = one_key(2, 1) | one_key(2, 5);
            apply_keys(m, 1'b0);
            drain("R5");
            release_all();
        end

        // R6: repeat after 128 ticks, then every 20
        cur_req = "R6";
        press_and_wait(3, 5, "R6");
        expect_evt(3, 5, 1'b1, 128, "R6");
        expect_evt(3, 5, 1'b1, 148, "R6");
        expect_evt(3, 5, 1'b1, 168, "R6");
        give_ticks(170);
        drain("R6");
        release_all();

        // R7: release reloads the countdown
        cur_req = "R7";
        press_and_wait(0, 4, "R7");
        give_ticks(100);
        release_all();
        give_ticks(40);
        press_and_wait(0, 4, "R7");
        expect_evt(0, 4, 1'b1, 128, "R7");
        give_ticks(130);
        drain("R7");
        release_all();

        // R8: direct switch to another key
        cur_req = "R8";
        press_and_wait(1, 1, "R8");
        give_ticks(100);
        expect_evt(4, 2, 1'b0, -1, "R8");
        apply_keys(one_key(4, 2), 1'b0);
        drain("R8");
        tick_count = 0;
        expect_evt(4, 2, 1'b1, 128, "R8");
        give_ticks(128);
        drain("R8");
        release_all();

        // R9a: release on the expiring tick's edge suppresses the repeat
        cur_req = "R9";
        press_and_wait(5, 0, "R9");
        give_ticks(127);
        apply_keys('0, 1'b1);
        sync_frame();
        give_ticks(40);
        drain("R9");
        // R9b: same switch reconfirmed on that edge lets the repeat through
        press_and_wait(5, 0, "R9");
        give_ticks(127);
        expect_evt(5, 0, 1'b1, 128, "R9");
        apply_keys(one_key(5, 0), 1'b1);
        drain("R9");
        release_all();
        // R9c: switch to a new key on that edge: only the press
        press_and_wait(5, 0, "R9");
        give_ticks(127);
        expect_evt(3, 3, 1'b0, -1, "R9");
        apply_keys(one_key(3, 3), 1'b1);
        drain("R9");
        tick_count = 0;
        expect_evt(3, 3, 1'b1, 128, "R9");
        give_ticks(128);
        drain("R9");
        release_all();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog %s: actual=timeout expected=finish", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule